// File: doc/BRIEF.md
# Multi-format audio serial port

This block is the slave side of a stereo digital audio link. Both the bit clock and the word/frame clock come from outside. The block runs directly on the bit clock and reads the level of the word/frame clock on every rising edge. It assembles incoming serial words into parallel left/right sample pairs for a playback path, and it shifts parallel capture samples out MSB first. A single bit counter serves both directions.

A static format select picks the framing:

- I²S: one bit of delay after each clock transition.
- Left-justified: no delay.
- Right-justified: the word ends on the last bit of the half period. This framing is receive only.
- Frame-sync (DSP): one sync pulse opens a frame that carries the left word and then the right word back to back.

A static word length selects 16 to 24 bits. Received samples are delivered with a one-cycle valid strobe. The capture side loads a transmit pair into a holding stage and receives a one-cycle request each time that pair is committed to a frame.

Top module: `aud_serial_port`

## Requirements
- R1: `fmt_i` encodes the framing as 0 = I²S, 1 = left-justified, 2 = right-justified, 3 = frame-sync. `wlen_i` is the word length in bits; values below 16 act as 16 and values above 24 act as 24.
- R2: I²S: the word clock low marks left and high marks right. The MSB is sampled on the second rising edge at which the new word clock level is seen.
- R3: Left-justified: the word clock high marks left and low marks right. The MSB is sampled on the first rising edge at which the new level is seen.
- R4: Right-justified: the word clock high marks left. The word is the last `wlen` bits sampled before the edge at which the opposite level is first seen, so its LSB sits on the last edge of the half period. In this mode `sdout_o` stays low and `tx_req_o` never pulses.
- R5: Frame-sync: the left MSB is sampled on the edge after the first edge that sees the sync high. The right MSB follows the left LSB on the very next edge.
- R6: Received words appear right-aligned on `rx_left_o`/`rx_right_o`, with bits above the word length zero. Bits sampled outside a word have no effect.
- R7: `rx_valid_o` is high for exactly one cycle after the edge that samples the right LSB (right-justified: after the edge that ends the right half). Both sample outputs update in that same cycle.
- R8: After each rising edge that samples word position k on receive, `sdout_o` carries bit k of the transmit word, counted from the MSB. Outside a word, `sdout_o` is low.
- R9: `tx_load_i` writes `tx_left_i`/`tx_right_i` into a holding pair. On the left word's first edge, the held pair is committed for the whole frame and `tx_req_o` pulses for one cycle. A load on that same edge goes to the next frame.
- R10: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Bit clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Framing select (static) |
| wlen_i | input | 5 | Word length in bits (static) |
| lrck_i | input | 1 | Word clock / frame sync |
| sdin_i | input | 1 | Serial receive data |
| sdout_o | output | 1 | Serial transmit data |
| rx_left_o | output | 24 | Received left sample, right-aligned |
| rx_right_o | output | 24 | Received right sample, right-aligned |
| rx_valid_o | output | 1 | One-cycle strobe for a new received pair |
| tx_left_i | input | 24 | Left sample to transmit, right-aligned |
| tx_right_i | input | 24 | Right sample to transmit, right-aligned |
| tx_load_i | input | 1 | Writes the transmit pair into the holding stage |
| tx_req_o | output | 1 | One-cycle pulse when the held pair is committed |

## Verification
The collision of interest is a capture-side load that lands on the same edge as the first bit of the left word. At that edge the serializer commits the held pair while the holding stage is being rewritten. Runs in left-justified and frame-sync modes place every load exactly on that edge. A behavioural model expects each frame to carry the pair loaded one frame earlier, and it compares `sdout_o` bit by bit on every clock, so a design that takes the new pair is caught on the first MSB. The other runs load away from that edge, which confirms that the normal path is unaffected.

// File: rtl/aud_sp_pkg.sv
`timescale 1ns/1ps
package aud_sp_pkg;
  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;
endpackage

// File: rtl/aud_sp_framer.sv
`timescale 1ns/1ps
module aud_sp_framer
  import aud_sp_pkg::*;
#(
  parameter int MAX_W = 24,
  localparam int WLW = $clog2(MAX_W + 1),
  localparam int CW  = $clog2(2 * MAX_W + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  fmt_e           fmt_i,
  input  logic [WLW-1:0] wlen_i,
  input  logic           lrck_i,
  output logic           bit_vld_o,
  output logic           left_o,
  output logic           first_o,
  output logic           last_o,
  output logic [WLW-1:0] idx_o,
  output logic           rj_end_o,
  output logic           rj_left_o
);
  logic          lrck_q, trans_q, rise_q, ch_left_q;
  logic [CW-1:0] cnt_q;
  logic          trans, rise, dsp, start, slot_left, busy, right_dsp;
  logic [CW-1:0] wlen_c, lim, pos, wpos;

  always_comb begin
    trans  = lrck_i ^ lrck_q;
    rise   = lrck_i & ~lrck_q;
    dsp    = (fmt_i == FMT_DSP);
    start     = 1'b0;
    slot_left = 1'b0;
    unique case (fmt_i)
      FMT_LJ:  begin start = trans;   slot_left = lrck_i;  end
      FMT_I2S: begin start = trans_q; slot_left = ~lrck_q; end
      FMT_DSP: begin start = rise_q;  slot_left = 1'b1;    end
      default: begin start = 1'b0;    slot_left = 1'b0;    end
    endcase
    wlen_c    = CW'(wlen_i);
    lim       = dsp ? (wlen_c << 1) : wlen_c;
    busy      = (cnt_q < lim);
    pos       = start ? '0 : cnt_q;
    right_dsp = dsp && (pos >= wlen_c);
    wpos      = right_dsp ? (pos - wlen_c) : pos;
  end

  assign bit_vld_o = start | busy;
  assign left_o    = dsp ? ~right_dsp : (start ? slot_left : ch_left_q);
  assign first_o   = (wpos == '0);
  assign last_o    = (wpos == wlen_c - CW'(1));
  assign idx_o     = WLW'(wlen_c - CW'(1) - wpos);
  assign rj_end_o  = trans && (fmt_i == FMT_RJ);
  assign rj_left_o = lrck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lrck_q    <= 1'b0;
      trans_q   <= 1'b0;
      rise_q    <= 1'b0;
      ch_left_q <= 1'b0;
      cnt_q     <= '1;  // idle
    end else begin
      lrck_q  <= lrck_i;
      trans_q <= trans;
      rise_q  <= rise;
      if (start) begin
        cnt_q     <= CW'(1);
        ch_left_q <= slot_left;
      end else if (busy) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assert_dsp_back2back_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == FMT_DSP && bit_vld_o && last_o && left_o) |=> (bit_vld_o && first_o && !left_o));

  assert_word_contig_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_o && !last_o) |=> bit_vld_o);
endmodule

// File: rtl/aud_sp_rx.sv
`timescale 1ns/1ps
module aud_sp_rx #(
  parameter int MAX_W = 24,
  localparam int WLW = $clog2(MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WLW-1:0]   wlen_i,
  input  logic             sdin_i,
  input  logic             bit_vld_i,
  input  logic             left_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic             rj_end_i,
  input  logic             rj_left_i,
  output logic [MAX_W-1:0] left_o,
  output logic [MAX_W-1:0] right_o,
  output logic             valid_o
);
  logic [MAX_W-1:0] acc_q, lhold_q, rj_sh_q, nxt, mask, rj_word;

  always_comb begin
    mask    = ~({MAX_W{1'b1}} << wlen_i);
    nxt     = {(first_i ? {(MAX_W-1){1'b0}} : acc_q[MAX_W-2:0]), sdin_i};
    rj_word = rj_sh_q & mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      lhold_q <= '0;
      rj_sh_q <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      rj_sh_q <= {rj_sh_q[MAX_W-2:0], sdin_i};
      if (bit_vld_i) begin
        acc_q <= nxt;
        if (last_i) begin
          if (left_i) lhold_q <= nxt;
          else begin
            left_o  <= lhold_q;
            right_o <= nxt;
            valid_o <= 1'b1;
          end
        end
      end
      // right-justified: word ends at the slot boundary
      if (rj_end_i) begin
        if (rj_left_i) lhold_q <= rj_word;
        else begin
          left_o  <= lhold_q;
          right_o <= rj_word;
          valid_o <= 1'b1;
        end
      end
    end
  end

  assert_valid_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (((left_o | right_o) & ~mask) == '0));
endmodule

// File: rtl/aud_sp_tx.sv
`timescale 1ns/1ps
module aud_sp_tx
  import aud_sp_pkg::*;
#(
  parameter int MAX_W = 24,
  localparam int WLW = $clog2(MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  fmt_e             fmt_i,
  input  logic             bit_vld_i,
  input  logic             left_i,
  input  logic             first_i,
  input  logic [WLW-1:0]   idx_i,
  input  logic [MAX_W-1:0] tx_left_i,
  input  logic [MAX_W-1:0] tx_right_i,
  input  logic             tx_load_i,
  output logic             sdout_o,
  output logic             tx_req_o
);
  logic [MAX_W-1:0] hold_l_q, hold_r_q, cur_l_q, cur_r_q, src;
  logic             commit;

  always_comb begin
    commit = bit_vld_i && first_i && left_i;
    src    = commit ? hold_l_q : (left_i ? cur_l_q : cur_r_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      cur_l_q  <= '0;
      cur_r_q  <= '0;
      sdout_o  <= 1'b0;
      tx_req_o <= 1'b0;
    end else begin
      if (tx_load_i) begin
        hold_l_q <= tx_left_i;
        hold_r_q <= tx_right_i;
      end
      if (commit) begin
        cur_l_q <= hold_l_q;
        cur_r_q <= hold_r_q;
      end
      tx_req_o <= commit;
      sdout_o  <= bit_vld_i ? src[idx_i] : 1'b0;
    end
  end

  assert_req_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |=> !tx_req_o);

  assert_rj_tx_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == FMT_RJ) |=> (!sdout_o && !tx_req_o));
endmodule

// File: rtl/aud_serial_port.sv
`timescale 1ns/1ps
module aud_serial_port
  import aud_sp_pkg::*;
#(
  parameter int MAX_W = 24,
  parameter int MIN_W = 16,
  localparam int WLW = $clog2(MAX_W + 1)
) (
  input  logic             sclk_i,
  input  logic             rst_ni,
  input  logic [1:0]       fmt_i,
  input  logic [WLW-1:0]   wlen_i,
  input  logic             lrck_i,
  input  logic             sdin_i,
  output logic             sdout_o,
  output logic [MAX_W-1:0] rx_left_o,
  output logic [MAX_W-1:0] rx_right_o,
  output logic             rx_valid_o,
  input  logic [MAX_W-1:0] tx_left_i,
  input  logic [MAX_W-1:0] tx_right_i,
  input  logic             tx_load_i,
  output logic             tx_req_o
);
  fmt_e           fmt;
  logic [WLW-1:0] wlen;
  logic           bit_vld, left, first, last, rj_end, rj_left;
  logic [WLW-1:0] idx;

  always_comb begin
    fmt = fmt_e'(fmt_i);
    if (wlen_i < WLW'(MIN_W))      wlen = WLW'(MIN_W);
    else if (wlen_i > WLW'(MAX_W)) wlen = WLW'(MAX_W);
    else                           wlen = wlen_i;
  end

  aud_sp_framer #(.MAX_W(MAX_W)) u_framer (
    .clk_i(sclk_i), .rst_ni(rst_ni), .fmt_i(fmt), .wlen_i(wlen), .lrck_i(lrck_i),
    .bit_vld_o(bit_vld), .left_o(left), .first_o(first), .last_o(last), .idx_o(idx),
    .rj_end_o(rj_end), .rj_left_o(rj_left)
  );

  aud_sp_rx #(.MAX_W(MAX_W)) u_rx (
    .clk_i(sclk_i), .rst_ni(rst_ni), .wlen_i(wlen), .sdin_i(sdin_i),
    .bit_vld_i(bit_vld), .left_i(left), .first_i(first), .last_i(last),
    .rj_end_i(rj_end), .rj_left_i(rj_left),
    .left_o(rx_left_o), .right_o(rx_right_o), .valid_o(rx_valid_o)
  );

  aud_sp_tx #(.MAX_W(MAX_W)) u_tx (
    .clk_i(sclk_i), .rst_ni(rst_ni), .fmt_i(fmt), .bit_vld_i(bit_vld), .left_i(left),
    .first_i(first), .idx_i(idx), .tx_left_i(tx_left_i), .tx_right_i(tx_right_i),
    .tx_load_i(tx_load_i), .sdout_o(sdout_o), .tx_req_o(tx_req_o)
  );
endmodule

// File: tb/aud_serial_port_test.sv
`timescale 1ns/1ps
module aud_serial_port_test;
  localparam int F = 3;     // data frames per run, plus one trailing frame
  localparam int MAXE = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic [4:0]  wlen = 5'd16;
  logic        lrck = 1'b0, sdin = 1'b0, tx_load = 1'b0;
  logic [23:0] tx_l = '0, tx_r = '0;
  logic        sdout, rx_valid, tx_req;
  logic [23:0] rx_l, rx_r;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  aud_serial_port uut (
    .sclk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .wlen_i(wlen), .lrck_i(lrck),
    .sdin_i(sdin), .sdout_o(sdout), .rx_left_o(rx_l), .rx_right_o(rx_r),
    .rx_valid_o(rx_valid), .tx_left_i(tx_l), .tx_right_i(tx_r),
    .tx_load_i(tx_load), .tx_req_o(tx_req)
  );

  // behavioural model: per-edge stimulus and expectations
  logic        lr_d[MAXE], sd_d[MAXE], exp_sd[MAXE], exp_rq[MAXE], exp_v[MAXE];
  logic [23:0] ev_l[MAXE], ev_r[MAXE];
  logic [23:0] rxw_l[8], rxw_r[8], txw_l[8], txw_r[8];

  task automatic chk(input string r, input int g, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s edge %0d: actual %h expected %h", r, g, act, exp);
    end
  endtask

  task automatic run(input string tag, input int f, input int wdrv, input int w, input int s, input int ld_loc);
    int n_e;
    logic [23:0] m;
    n_e = (F + 1) * 2 * s;
    m = ~(24'hFFFFFF << w);
    // reset phase, R10
    rst_n = 1'b0; fmt = 2'(f); wlen = 5'(wdrv); lrck = 1'b0; sdin = 1'b0; tx_load = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 sdout", -1, 24'(sdout), 24'd0);
    chk("R10 valid", -1, 24'(rx_valid), 24'd0);
    chk("R10 req", -1, 24'(tx_req), 24'd0);
    chk("R10 left", -1, rx_l, 24'd0);
    chk("R10 right", -1, rx_r, 24'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      rxw_l[i] = (i < F) ? ($urandom & m) : 24'd0;
      rxw_r[i] = (i < F) ? ($urandom & m) : 24'd0;
      txw_l[i] = $urandom & m;
      txw_r[i] = $urandom & m;
    end
    for (int e = 0; e < n_e; e++) begin
      int l;
      l = e % (2 * s);
      sd_d[e] = 1'($urandom);  // junk outside words
      exp_sd[e] = 1'b0; exp_rq[e] = 1'b0; exp_v[e] = 1'b0; ev_l[e] = '0; ev_r[e] = '0;
      case (f)
        0: lr_d[e] = (l >= s);
        3: lr_d[e] = (l == 0);
        default: lr_d[e] = (l < s);
      endcase
    end
    for (int n = 0; n <= F; n++) begin
      int b, pl, pr;
      b = n * 2 * s;
      if (f == 2) begin
        for (int k = 0; k < w; k++) begin
          sd_d[b + s - w + k]     = rxw_l[n][w-1-k];
          sd_d[b + 2 * s - w + k] = rxw_r[n][w-1-k];
        end
        exp_v[b] = 1'b1;
        ev_l[b] = (n > 0) ? rxw_l[n-1] : 24'd0;
        ev_r[b] = (n > 0) ? rxw_r[n-1] : 24'd0;
      end else begin
        pl = (f == 1) ? 0 : 1;
        pr = (f == 1) ? s : ((f == 0) ? s + 1 : 1 + w);
        for (int k = 0; k < w; k++) begin
          sd_d[b + pl + k] = rxw_l[n][w-1-k];
          exp_sd[b + pl + k] = txw_l[n][w-1-k];
          sd_d[b + pr + k] = rxw_r[n][w-1-k];
          exp_sd[b + pr + k] = txw_r[n][w-1-k];
        end
        exp_rq[b + pl] = 1'b1;
        exp_v[b + pr + w - 1] = 1'b1;
        ev_l[b + pr + w - 1] = rxw_l[n];
        ev_r[b + pr + w - 1] = rxw_r[n];
      end
    end
    // pre-roll: settle word clock, preload frame 0 pair
    for (int p = 0; p < 3; p++) begin
      lrck = (f == 0); sdin = 1'b0;
      tx_load = (p == 0); tx_l = txw_l[0]; tx_r = txw_r[0];
      @(posedge clk); @(negedge clk);
    end
    for (int g = 0; g < n_e; g++) begin
      int n, l;
      n = g / (2 * s); l = g % (2 * s);
      lrck = lr_d[g]; sdin = sd_d[g];
      tx_load = (l == ld_loc); tx_l = txw_l[n + 1]; tx_r = txw_r[n + 1];
      @(posedge clk); @(negedge clk);
      chk({"R8 sdout ", tag}, g, 24'(sdout), 24'(exp_sd[g]));
      chk({"R9 req ", tag}, g, 24'(tx_req), 24'(exp_rq[g]));
      chk({"R7 valid ", tag}, g, 24'(rx_valid), 24'(exp_v[g]));
      if (exp_v[g]) begin
        chk({"R6 left ", tag}, g, rx_l, ev_l[g]);
        chk({"R6 right ", tag}, g, rx_r, ev_r[g]);
      end
    end
    tx_load = 1'b0;
  endtask

  initial begin
    run("R2 i2s w16",          0, 16, 16, 32, 3);
    run("R3 lj w24 packed",    1, 24, 24, 24, 3);
    run("R3 lj w20 load@MSB",  1, 20, 20, 32, 0);
    run("R4 rj w24",           2, 24, 24, 32, 3);
    run("R4 rj w16",           2, 16, 16, 32, 5);
    run("R5 dsp w24",          3, 24, 24, 32, 3);
    run("R5 dsp w16 load@MSB", 3, 16, 16, 32, 1);
    run("R1 i2s wlen31->24",   0, 31, 24, 32, 3);
    run("R1 lj wlen5->16",     1,  5, 16, 32, 3);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule